// File: doc/BRIEF.md
# Two-Port Segment Token Arbiter

This block holds a set of hardware token latches that sit beside a shared two-ported memory. Two masters run with no timing relationship to each other, one on the left port and one on the right. Each master claims a logical segment of the memory before using it. A master selects a latch with a 3-bit index and pulses its own active-low semaphore enable. With the write strobe low and the data bit at 0, the access asks for the token. With the data bit at 1, it gives the token back. The master then reads the latch. A 0 on its one-bit data output means it owns that segment, and a 1 means it does not.

Both ports enter a single clock domain. The enable strobe of each port passes through a synchroniser of two flip-flops, and the block acts on each falling edge of the synchronised strobe exactly once. When a token is handed back, a request from the other side that is still waiting takes the token over in the same update. When both sides ask for the same free latch in the same cycle, the left side wins and the right request waits.

Top module: `seg_token_arbiter`

## Requirements
- R1: There are eight token latches, selected by the 3-bit index `*_sel`. A request or release on one latch never changes the ownership of any other latch.
- R2: An access takes effect only on a falling edge of that port's `*_sem_n`, and once per edge. While `*_sem_n` stays high, changes on `*_wr_n`, `*_sel` and `*_din` leave every latch unchanged.
- R3: A write (`*_wr_n`=0) with `*_din`=0 to a free latch grants that latch to the writing port. That port then reads 0 on `*_dout` for the latch.
- R4: `*_dout` is 1 whenever the selected latch is not owned by that port. This covers latches that are free, latches held by the other side and latches that are only requested.
- R5: While one side holds a latch, a request from the other side is not granted. The other side keeps reading 1 and the holder keeps reading 0.
- R6: When both ports request the same free latch in the same clock cycle, the left port is granted and the right request stays pending.
- R7: A write with `*_din`=1 by the owner frees the latch. If the other side has a pending request on that latch, that side becomes owner in the same update.
- R8: A write with `*_din`=1 by a port that does not own the latch leaves the owner unchanged, and it withdraws any pending request that port has on the latch.
- R9: After reset every latch is free and reads 1 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sem_n | input | 1 | Left semaphore enable, active low, asynchronous |
| l_wr_n | input | 1 | Left write strobe, low = write, high = read |
| l_sel | input | 3 | Left latch index |
| l_din | input | 1 | Left token data bit, 0 = request, 1 = release |
| l_dout | output | 1 | Left read-back, 0 = left owns the selected latch |
| r_sem_n | input | 1 | Right semaphore enable, active low, asynchronous |
| r_wr_n | input | 1 | Right write strobe, low = write, high = read |
| r_sel | input | 3 | Right latch index |
| r_din | input | 1 | Right token data bit, 0 = request, 1 = release |
| r_dout | output | 1 | Right read-back, 0 = right owns the selected latch |

## Verification
The assertions assume that each port holds `*_wr_n`, `*_sel` and `*_din` steady from before its enable falls until the enable has passed both synchroniser stages. They also assume that the read-back index is held for at least one clock before the output is judged. The stimulus follows this rule. It changes every qualifier on a falling clock edge before it lowers the enable, holds the enable low for four clocks, and only then releases it. The one exception is the check that inputs are ignored while the enable stays high, where the qualifiers move every cycle. Simultaneous requests are produced by lowering both enables on the same falling clock edge, so the two synchronised strobes fall in the same cycle.

// File: rtl/seg_token_pkg.sv
// Package: shared types and constants for the segment token arbiter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package seg_token_pkg;

    // Ownership state of one token latch
    typedef enum logic [1:0] {
        OWN_FREE  = 2'b00,
        OWN_LEFT  = 2'b01,
        OWN_RIGHT = 2'b10
    } owner_t;

    localparam int unsigned DEF_TOKENS = 8;
    localparam int unsigned DEF_SYNC   = 2;

endpackage

// File: rtl/seg_port_front.sv
// Module: seg_port_front
// Brings one asynchronous semaphore port into the clock domain. The enable
// passes through SYNC_STAGES flops, and a falling edge of the synchronised
// enable yields one single-cycle event. The event is decoded into one-hot
// request (write 0) and release (write 1) pulses per latch.
// Assumes: wr_n, sel and din are steady while the enable is being synchronised.
module seg_port_front #(
    parameter int unsigned NUM_TOKENS  = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SEL_W      = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sem_n,
    input  logic                  wr_n,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  din,
    output logic [NUM_TOKENS-1:0] req,
    output logic [NUM_TOKENS-1:0] rel
);

    logic [SYNC_STAGES:0] chain;
    logic                 fall;

    // Shift the enable through the synchroniser plus one edge-detect flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], sem_n};
        end
    end

    // One event per falling edge of the synchronised enable
    always_comb begin
        fall = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
    end

    // Decode the event into per-latch request and release pulses
    for (genvar g = 0; g < NUM_TOKENS; g++) begin : g_dec
        always_comb begin
            req[g] = fall && !wr_n && (sel == SEL_W'(g)) && !din;
            rel[g] = fall && !wr_n && (sel == SEL_W'(g)) &&  din;
        end
    end

endmodule

// File: rtl/seg_token_cell.sv
// Module: seg_token_cell
// One token latch. It keeps the owner and a pending-request flag per side.
// A release is applied first, then the grant is resolved on the result, so
// a waiting request takes the token over in the same cycle. On a tie the
// left side wins.
// Assumes: the request and release pulses are single-cycle events.
module seg_token_cell
    import seg_token_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r
);

    owner_t owner_q, owner_rel, owner_d;
    logic   pend_l_q, pend_r_q, pend_l_d, pend_r_d;
    logic   want_l, want_r;

    // Apply releases by the current owner
    always_comb begin
        owner_rel = owner_q;
        if (owner_q == OWN_LEFT && l_rel) owner_rel = OWN_FREE;
        if (owner_q == OWN_RIGHT && r_rel) owner_rel = OWN_FREE;
    end

    // Merge new requests with pending ones; a write of 1 withdraws a request
    always_comb begin
        want_l = (pend_l_q || l_req) && !l_rel && (owner_q != OWN_LEFT);
        want_r = (pend_r_q || r_req) && !r_rel && (owner_q != OWN_RIGHT);
    end

    // Resolve the grant on a free latch, left first
    always_comb begin
        owner_d  = owner_rel;
        pend_l_d = want_l;
        pend_r_d = want_r;
        if (owner_rel == OWN_FREE) begin
            if (want_l) begin
                owner_d  = OWN_LEFT;
                pend_l_d = 1'b0;
            end else if (want_r) begin
                owner_d  = OWN_RIGHT;
                pend_r_d = 1'b0;
            end
        end
    end

    // Hold ownership and pending state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= OWN_FREE;
            pend_l_q <= 1'b0;
            pend_r_q <= 1'b0;
        end else begin
            owner_q  <= owner_d;
            pend_l_q <= pend_l_d;
            pend_r_q <= pend_r_d;
        end
    end

    // Expose per-side ownership
    always_comb begin
        own_l = (owner_q == OWN_LEFT);
        own_r = (owner_q == OWN_RIGHT);
    end

endmodule

// File: rtl/seg_readback.sv
// Module: seg_readback
// Registered read-back for one port. It drives 0 when this port owns the
// selected latch and 1 otherwise.
// Assumes: sel is held steady for a clock before the result is used.
module seg_readback #(
    parameter int unsigned NUM_TOKENS = 8,
    localparam int unsigned SEL_W     = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_TOKENS-1:0] own,
    input  logic [SEL_W-1:0]      sel,
    output logic                  dout
);

    // Gate the read so that only the owner sees 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b1;
        end else begin
            dout <= ~own[sel];
        end
    end

endmodule

// File: rtl/seg_token_arbiter.sv
// Module: seg_token_arbiter (top)
// A bank of token latches shared by two asynchronous ports. Each port has
// a front end that synchronises its enable and decodes accesses, one cell
// per latch holds ownership, and a read-back stage per port reports
// ownership of the selected latch.
// Assumes: port qualifiers are steady around each enable falling edge.
module seg_token_arbiter #(
    parameter int unsigned NUM_TOKENS  = seg_token_pkg::DEF_TOKENS,
    parameter int unsigned SYNC_STAGES = seg_token_pkg::DEF_SYNC,
    localparam int unsigned SEL_W      = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_sem_n,
    input  logic             l_wr_n,
    input  logic [SEL_W-1:0] l_sel,
    input  logic             l_din,
    output logic             l_dout,
    input  logic             r_sem_n,
    input  logic             r_wr_n,
    input  logic [SEL_W-1:0] r_sel,
    input  logic             r_din,
    output logic             r_dout
);

    logic [NUM_TOKENS-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_TOKENS-1:0] own_l, own_r;

    seg_port_front #(.NUM_TOKENS(NUM_TOKENS), .SYNC_STAGES(SYNC_STAGES)) u_front_l (
        .clk(clk), .rst_n(rst_n), .sem_n(l_sem_n), .wr_n(l_wr_n),
        .sel(l_sel), .din(l_din), .req(l_req), .rel(l_rel)
    );

    seg_port_front #(.NUM_TOKENS(NUM_TOKENS), .SYNC_STAGES(SYNC_STAGES)) u_front_r (
        .clk(clk), .rst_n(rst_n), .sem_n(r_sem_n), .wr_n(r_wr_n),
        .sel(r_sel), .din(r_din), .req(r_req), .rel(r_rel)
    );

    for (genvar g = 0; g < NUM_TOKENS; g++) begin : g_cell
        seg_token_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .own_l(own_l[g]), .own_r(own_r[g])
        );
    end

    seg_readback #(.NUM_TOKENS(NUM_TOKENS)) u_rb_l (
        .clk(clk), .rst_n(rst_n), .own(own_l), .sel(l_sel), .dout(l_dout)
    );

    seg_readback #(.NUM_TOKENS(NUM_TOKENS)) u_rb_r (
        .clk(clk), .rst_n(rst_n), .own(own_r), .sel(r_sel), .dout(r_dout)
    );

endmodule

// File: rtl/seg_token_checker.sv
// Module: seg_token_checker
// Temporal checks on the arbiter, bound to the top module.
// Assumes: read-back indices are held for a clock before they are judged.
module seg_token_checker #(
    parameter int unsigned NUM_TOKENS = 8,
    parameter int unsigned SEL_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [SEL_W-1:0]      l_sel,
    input logic [SEL_W-1:0]      r_sel,
    input logic                  l_dout,
    input logic                  r_dout,
    input logic [NUM_TOKENS-1:0] l_req,
    input logic [NUM_TOKENS-1:0] l_rel,
    input logic [NUM_TOKENS-1:0] r_req,
    input logic [NUM_TOKENS-1:0] r_rel,
    input logic [NUM_TOKENS-1:0] own_l,
    input logic [NUM_TOKENS-1:0] own_r
);

    logic seen_clk;

    // Mark the first clock so that $past only looks at sampled values
    always_ff @(posedge clk) begin
        seen_clk <= 1'b1;
    end

    AST_RESET_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_clk && $past(!rst_n)) |-> (l_dout && r_dout)); // R9

    AST_READ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_clk && $past(l_sel) == $past(r_sel)) |-> (l_dout || r_dout)); // R5

    for (genvar g = 0; g < NUM_TOKENS; g++) begin : g_chk
        AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_clk && $past(own_l[g]) && !$past(l_rel[g])) |-> own_l[g]); // R5

        AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_clk && $past(own_r[g]) && !$past(r_rel[g])) |-> own_r[g]); // R8

        AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_clk && $past(l_req[g] && r_req[g] && !own_l[g] && !own_r[g]))
            |-> own_l[g]); // R6

        AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_clk && $past(own_l[g] && l_rel[g])) |-> !own_l[g]); // R7
    end

endmodule

bind seg_token_arbiter seg_token_checker #(.NUM_TOKENS(NUM_TOKENS), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .l_sel(l_sel), .r_sel(r_sel),
    .l_dout(l_dout), .r_dout(r_dout),
    .l_req(l_req), .l_rel(l_rel), .r_req(r_req), .r_rel(r_rel),
    .own_l(own_l), .own_r(own_r)
);

// File: tb/seg_token_arbiter_bench.sv
// Bench: sweeps every latch through request, contention, tie, withdrawal
// and hand-over, against an arithmetic ownership model.
module seg_token_arbiter_bench;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sem_n = 1'b1, l_wr_n = 1'b1, l_din = 1'b1;
    logic       r_sem_n = 1'b1, r_wr_n = 1'b1, r_din = 1'b1;
    logic [2:0] l_sel = '0, r_sel = '0;
    logic       l_dout, r_dout;

    int checks = 0;
    int failures = 0;

    // Model: 0 free, 1 left, 2 right
    int  m_own [N];
    bit  m_pl  [N];
    bit  m_pr  [N];

    seg_token_arbiter u_seg_token_arbiter (
        .clk(clk), .rst_n(rst_n),
        .l_sem_n(l_sem_n), .l_wr_n(l_wr_n), .l_sel(l_sel), .l_din(l_din), .l_dout(l_dout),
        .r_sem_n(r_sem_n), .r_wr_n(r_wr_n), .r_sel(r_sel), .r_din(r_din), .r_dout(r_dout)
    );

    always #4 clk = ~clk;

    // Apply one update step: release first, then left-first grant
    task automatic model_step(input bit lv, input bit ld, input int ls,
                              input bit rv, input bit rd, input int rs);
        for (int i = 0; i < N; i++) begin
            bit lq, lr, rq, rr, wl, wr;
            int o;
            lq = lv && ls == i && !ld;  lr = lv && ls == i && ld;
            rq = rv && rs == i && !rd;  rr = rv && rs == i && rd;
            o = m_own[i];
            wl = (m_pl[i] || lq) && !lr && o != 1;
            wr = (m_pr[i] || rq) && !rr && o != 2;
            if ((o == 1 && lr) || (o == 2 && rr)) o = 0;
            if (o == 0 && wl) begin o = 1; wl = 0; end
            else if (o == 0 && wr) begin o = 2; wr = 0; end
            m_own[i] = o; m_pl[i] = wl; m_pr[i] = wr;
        end
    endtask

    // One access on one or both ports, enables falling together
    task automatic access(input bit lv, input bit ld, input int ls,
                          input bit rv, input bit rd, input int rs);
        @(negedge clk);
        if (lv) begin l_wr_n = 0; l_din = ld; l_sel = 3'(ls); end
        if (rv) begin r_wr_n = 0; r_din = rd; r_sel = 3'(rs); end
        @(negedge clk);
        if (lv) l_sem_n = 0;
        if (rv) r_sem_n = 0;
        repeat (4) @(negedge clk);
        l_sem_n = 1; r_sem_n = 1;
        @(negedge clk);
        l_wr_n = 1; r_wr_n = 1;
        repeat (3) @(negedge clk);
        model_step(lv, ld, ls, rv, rd, rs);
    endtask

    // Read every latch on both ports and compare with the model
    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++) begin
            bit el, er;
            @(negedge clk);
            l_sel = 3'(i); r_sel = 3'(i);
            @(negedge clk);
            @(negedge clk);
            el = (m_own[i] != 1);
            er = (m_own[i] != 2);
            checks += 2;
            if (l_dout !== el) begin
                failures++;
                $display("FAIL %s left latch %0d dout=%b expected=%b", tag, i, l_dout, el);
            end
            if (r_dout !== er) begin
                failures++;
                $display("FAIL %s right latch %0d dout=%b expected=%b", tag, i, r_dout, er);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_own[i] = 0; m_pl[i] = 0; m_pr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R9 reset");

        // R2: qualifiers move while enables stay high
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            l_wr_n = k[0]; l_din = k[1]; l_sel = 3'(k);
            r_wr_n = k[1]; r_din = k[0]; r_sel = 3'(k + 3);
        end
        l_wr_n = 1; r_wr_n = 1;
        check_all("R2 idle");

        for (int i = 0; i < N; i++) begin
            int j;
            j = (i + 1) % N;
            access(1, 0, i, 0, 0, 0);      check_all("R3 left grant");
            access(0, 0, 0, 1, 0, i);      check_all("R5 right blocked");
            access(0, 0, 0, 1, 0, j);      check_all("R1 other latch");
            access(0, 0, 0, 1, 1, i);      check_all("R8 withdraw");
            access(1, 1, i, 0, 0, 0);      check_all("R8 no handover after withdraw");
            access(0, 0, 0, 1, 1, j);      check_all("R4 right release other");
            access(1, 0, i, 1, 0, i);      check_all("R6 tie left wins");
            access(0, 0, 0, 1, 1, i);      check_all("R8 non-owner release");
            access(0, 0, 0, 1, 0, i);      check_all("R5 re-request");
            access(1, 1, i, 0, 0, 0);      check_all("R7 hand-over");
            access(1, 1, i, 0, 0, 0);      check_all("R8 left non-owner");
            access(0, 0, 0, 1, 1, i);      check_all("R7 right release");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule